// File: doc/BRIEF.md
# Scanline and Vertical Interrupt Generator

This block paces the interrupt side of a tile-based video processor one video line at a time. A line strobe marks the start of each line. During the visible part of the frame, a down-counter loaded from a software-set reload value is stepped once per line. Each time it runs out, a line interrupt becomes pending and the counter is reloaded. The visible region is normally 224 lines. It grows to 240 lines when the 50 Hz (PAL) timing is selected together with the tall-screen mode.

The first line after the visible region gets one more counter step. It then sets the vertical-blank status bit and marks a vertical interrupt as pending. The request for that interrupt (priority level 6) is held back for a fixed number of system clocks after the line strobe. Line interrupts use priority level 4. Each request stays raised until its acknowledge pulse arrives, and the encoded level output favours level 6.

The frame restarts when an explicit frame strobe arrives or after the last line of the frame. The last line is fixed by the selected timing standard.

Top module: `scanline_irq_gen`

## Requirements
- R1: A restart (`frame_start`, or the automatic wrap) reloads the line counter from `hint_reload`, clears `vblank` and `vint_pend`, and cancels a pending vertical-interrupt lag. `frame_start` takes precedence over a `line_adv` in the same cycle.
- R2: Line index 0 is the first strobe after a restart. On each visible line the counter is checked: if it is zero it reloads and `hint_pend` sets, otherwise it decrements. With reload value N, `hint_pend` sets on check index j exactly when (j+1) mod (N+1) = 0.
- R3: A line-counter expiry sets `irq_req4` only when `hint_en` is 1. `hint_pend` sets regardless of `hint_en`.
- R4: The number of visible lines is `ACT_TALL` when both `pal_sel` and `tall_mode` are 1. Otherwise it is `ACT_SHORT`, so `tall_mode` has no effect with `pal_sel` = 0.
- R5: The line whose index equals the visible-line count performs one more counter check and sets `vblank` and `vint_pend`. `vblank` then holds until the next restart.
- R6: `irq_req6` rises exactly `VLAG` clocks after the clock edge that captured the vertical-blank line strobe. It rises only if `vint_en` is 1 at that moment.
- R7: The lines after the vertical-blank line perform no counter check, so `hint_pend` never sets on them.
- R8: The frame holds `LINES_PAL` lines when `pal_sel` is 1 and `LINES_NTSC` lines otherwise. The strobe of the last line restarts the frame as in R1.
- R9: `ack_h` clears `hint_pend` and `irq_req4`. `ack_v` clears `vint_pend` and `irq_req6`. A set in the same cycle wins over the clear.
- R10: `irq_level` is 6 while `irq_req6` is 1, otherwise 4 while `irq_req4` is 1, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle frame restart strobe |
| line_adv | input | 1 | One-cycle strobe at the start of each line |
| pal_sel | input | 1 | 1 selects 50 Hz frame timing |
| tall_mode | input | 1 | Tall-screen mode bit (counts only with pal_sel) |
| hint_reload | input | HW | Line-interrupt reload value |
| hint_en | input | 1 | Line-interrupt request enable |
| vint_en | input | 1 | Vertical-interrupt request enable |
| ack_h | input | 1 | Acknowledge for the line interrupt |
| ack_v | input | 1 | Acknowledge for the vertical interrupt |
| hint_pend | output | 1 | Line-interrupt pending flag |
| vint_pend | output | 1 | Vertical-interrupt pending flag |
| vblank | output | 1 | Vertical-blank status |
| irq_req4 | output | 1 | Level-4 request |
| irq_req6 | output | 1 | Level-6 request |
| irq_level | output | 3 | Highest pending request level (6, 4 or 0) |

## Verification
The bench builds the block with 4 and 6 visible lines, 7 and 9 total lines and a lag of 5 clocks. A full frame therefore takes only a few dozen cycles. With these sizes the bench can sweep every combination of timing standard, tall mode, both enables and reload values 0 to 9. Reload values above the visible-line count are included, so each sweep covers expiries on the vertical-blank line, no expiry at all, and the automatic wrap into a second frame. A separate run issues a frame restart during the vertical-interrupt lag.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef struct packed {
        logic hpend;
        logic vpend;
        logic vblank;
        logic req4;
        logic req6;
    } irq_state_t;

    localparam logic [2:0] LVL_NONE = 3'd0;
    localparam logic [2:0] LVL_LINE = 3'd4;
    localparam logic [2:0] LVL_VERT = 3'd6;

endpackage

// File: rtl/sirq_line_tracker.sv
module sirq_line_tracker #(
    parameter int LINES_NTSC = 262,
    parameter int LINES_PAL  = 313,
    parameter int ACT_SHORT  = 224,
    parameter int ACT_TALL   = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic line_adv,
    input  logic pal_sel,
    input  logic tall_mode,
    output logic restart,
    output logic step_active,
    output logic step_vbl
);
    localparam int LMAX = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC;
    localparam int LW   = $clog2(LMAX + 1);

    typedef struct packed {
        logic [LW-1:0] line;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic [LW-1:0] act_lines;
    logic [LW-1:0] last_line;
    logic          adv;

    always_comb begin
        st_d      = st_q;
        act_lines = (pal_sel && tall_mode) ? LW'(ACT_TALL) : LW'(ACT_SHORT);
        last_line = pal_sel ? LW'(LINES_PAL - 1) : LW'(LINES_NTSC - 1);
        adv       = line_adv && !frame_start;
        restart     = frame_start || (adv && (st_q.line >= last_line));
        step_active = adv && (st_q.line < act_lines);
        step_vbl    = adv && (st_q.line == act_lines);
        if (restart) begin
            st_d.line = '0;
        end else if (adv) begin
            st_d.line = st_q.line + LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sirq_line_counter.sv
module sirq_line_counter #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    input  logic [HW-1:0] reload,
    output logic          expire
);
    typedef struct packed {
        logic [HW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = step && !restart && (st_q.cnt == '0);
        if (restart) begin
            st_d.cnt = reload;
        end else if (step) begin
            st_d.cnt = (st_q.cnt == '0) ? reload : st_q.cnt - HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sirq_lag_timer.sv
module sirq_lag_timer #(
    parameter int VLAG = 68
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic fire
);
    localparam int LAGW = $clog2(VLAG + 1);

    typedef struct packed {
        logic            run;
        logic [LAGW-1:0] cnt;
    } lag_state_t;

    lag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = st_q.run && (st_q.cnt == LAGW'(1)) && !cancel;
        if (cancel) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = LAGW'(VLAG);
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt - LAGW'(1);
            if (st_q.cnt == LAGW'(1)) begin
                st_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
    import sirq_pkg::*;
#(
    parameter int HW         = 8,
    parameter int LINES_NTSC = 262,
    parameter int LINES_PAL  = 313,
    parameter int ACT_SHORT  = 224,
    parameter int ACT_TALL   = 240,
    parameter int VLAG       = 68
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_adv,
    input  logic          pal_sel,
    input  logic          tall_mode,
    input  logic [HW-1:0] hint_reload,
    input  logic          hint_en,
    input  logic          vint_en,
    input  logic          ack_h,
    input  logic          ack_v,
    output logic          hint_pend,
    output logic          vint_pend,
    output logic          vblank,
    output logic          irq_req4,
    output logic          irq_req6,
    output logic [2:0]    irq_level
);
    irq_state_t st_d, st_q;
    logic restart, step_active, step_vbl, h_expire, lag_fire;

    sirq_line_tracker #(
        .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL),
        .ACT_SHORT(ACT_SHORT),   .ACT_TALL(ACT_TALL)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_adv(line_adv),
        .pal_sel(pal_sel), .tall_mode(tall_mode), .restart(restart),
        .step_active(step_active), .step_vbl(step_vbl)
    );

    sirq_line_counter #(.HW(HW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .step(step_active || step_vbl), .reload(hint_reload), .expire(h_expire)
    );

    sirq_lag_timer #(.VLAG(VLAG)) u_lag (
        .clk(clk), .rst_n(rst_n), .start(step_vbl), .cancel(restart), .fire(lag_fire)
    );

    always_comb begin
        st_d = st_q;
        if (ack_h) begin
            st_d.hpend = 1'b0;
            st_d.req4  = 1'b0;
        end
        if (h_expire) begin
            st_d.hpend = 1'b1;
            if (hint_en) st_d.req4 = 1'b1;
        end
        if (ack_v) begin
            st_d.vpend = 1'b0;
            st_d.req6  = 1'b0;
        end
        if (lag_fire && vint_en) st_d.req6 = 1'b1;
        if (restart) begin
            st_d.vblank = 1'b0;
            st_d.vpend  = 1'b0;
        end else if (step_vbl) begin
            st_d.vblank = 1'b1;
            st_d.vpend  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hint_pend = st_q.hpend;
    assign vint_pend = st_q.vpend;
    assign vblank    = st_q.vblank;
    assign irq_req4  = st_q.req4;
    assign irq_req6  = st_q.req6;
    assign irq_level = st_q.req6 ? LVL_VERT : (st_q.req4 ? LVL_LINE : LVL_NONE);
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       line_adv,
    input logic       hint_en,
    input logic       vint_en,
    input logic       ack_h,
    input logic       ack_v,
    input logic       hint_pend,
    input logic       vint_pend,
    input logic       vblank,
    input logic       irq_req4,
    input logic       irq_req6,
    input logic [2:0] irq_level
);
    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!vblank && !vint_pend)); // R1

    AST_HPEND_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hint_pend) |-> ($past(line_adv) && !$past(frame_start))); // R2

    AST_REQ4_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req4) |-> ($past(hint_en) && hint_pend)); // R3

    AST_VBLANK_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> ($past(line_adv) && !$past(frame_start))); // R5

    AST_VBLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && !frame_start && !line_adv) |=> vblank); // R5

    AST_REQ6_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req6) |-> $past(vint_en)); // R6

    AST_ACK_H_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_h && !line_adv) |=> (!hint_pend && !irq_req4)); // R9

    AST_ACK_V_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_v && !line_adv) |=> !vint_pend); // R9

    AST_LEVEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != 3'd0) |-> (irq_req4 || irq_req6)); // R10
endmodule

bind scanline_irq_gen sirq_checker u_sirq_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_adv(line_adv),
    .hint_en(hint_en), .vint_en(vint_en), .ack_h(ack_h), .ack_v(ack_v),
    .hint_pend(hint_pend), .vint_pend(vint_pend), .vblank(vblank),
    .irq_req4(irq_req4), .irq_req6(irq_req6), .irq_level(irq_level)
);

// File: tb/test_scanline_irq_gen.sv
`timescale 1ns/1ps
module test_scanline_irq_gen;
    localparam int HW  = 8;
    localparam int NT  = 7;
    localparam int PL  = 9;
    localparam int AS  = 4;
    localparam int AT  = 6;
    localparam int LAG = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, line_adv = 1'b0, pal_sel = 1'b0, tall_mode = 1'b0;
    logic [HW-1:0] hint_reload = '0;
    logic hint_en = 1'b0, vint_en = 1'b0, ack_h = 1'b0, ack_v = 1'b0;
    logic hint_pend, vint_pend, vblank, irq_req4, irq_req6;
    logic [2:0] irq_level;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    scanline_irq_gen #(
        .HW(HW), .LINES_NTSC(NT), .LINES_PAL(PL),
        .ACT_SHORT(AS), .ACT_TALL(AT), .VLAG(LAG)
    ) i_scanline_irq_gen (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_adv(line_adv),
        .pal_sel(pal_sel), .tall_mode(tall_mode), .hint_reload(hint_reload),
        .hint_en(hint_en), .vint_en(vint_en), .ack_h(ack_h), .ack_v(ack_v),
        .hint_pend(hint_pend), .vint_pend(vint_pend), .vblank(vblank),
        .irq_req4(irq_req4), .irq_req6(irq_req6), .irq_level(irq_level)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic pulse_line();
        @(negedge clk) line_adv = 1'b1;
        @(negedge clk) line_adv = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk) begin ack_h = 1'b1; ack_v = 1'b1; end
        @(negedge clk) begin ack_h = 1'b0; ack_v = 1'b0; end
    endtask

    task automatic run_line(input int y, input int act, input int tot,
                            input int rl, input int hen, input int ven);
        int hev, exp_lvl;
        pulse_line();
        hev = ((y <= act) && (((y + 1) % (rl + 1)) == 0)) ? 1 : 0;
        chk((y > act) ? "R7 hint_pend" : "R2 hint_pend", int'(hint_pend), hev);
        chk("R3 irq_req4", int'(irq_req4), hev & hen);
        if (y == tot - 1)
            chk("R8 vblank after wrap", int'(vblank), 0);
        else if (y == act - 1)
            chk("R4 vblank on last visible line", int'(vblank), 0);
        else
            chk("R5 vblank", int'(vblank), (y >= act) ? 1 : 0);
        chk("R5 vint_pend", int'(vint_pend), (y == act) ? 1 : 0);
        exp_lvl = (hev & hen) ? 4 : 0;
        if (y == act) begin
            repeat (LAG - 1) @(negedge clk);
            chk("R6 irq_req6 before lag", int'(irq_req6), 0);
            @(negedge clk);
            chk("R6 irq_req6 after lag", int'(irq_req6), ven);
            if (ven != 0) exp_lvl = 6;
        end
        chk("R10 irq_level", int'(irq_level), exp_lvl);
        pulse_ack();
        chk("R9 ack clears", int'({hint_pend, irq_req4, vint_pend, irq_req6}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", int'({hint_pend, vint_pend, vblank, irq_req4, irq_req6}), 0);
        chk("R10 reset level", int'(irq_level), 0);

        for (int pal = 0; pal < 2; pal++) begin
            for (int tall = 0; tall < 2; tall++) begin
                for (int rl = 0; rl < 10; rl++) begin
                    for (int en = 0; en < 4; en++) begin
                        int act, tot;
                        act = (pal == 1 && tall == 1) ? AT : AS;
                        tot = (pal == 1) ? PL : NT;
                        @(negedge clk);
                        pal_sel = pal[0]; tall_mode = tall[0];
                        hint_reload = HW'(rl); hint_en = en[0]; vint_en = en[1];
                        pulse_frame();
                        chk("R1 frame start clears", int'({vblank, vint_pend}), 0);
                        for (int fr = 0; fr < 2; fr++)
                            for (int y = 0; y < tot; y++)
                                run_line(y, act, tot, rl, int'(en[0]), int'(en[1]));
                    end
                end
            end
        end

        // restart during the vertical lag
        @(negedge clk);
        pal_sel = 1'b0; tall_mode = 1'b0; hint_reload = '0;
        hint_en = 1'b1; vint_en = 1'b1;
        pulse_frame();
        for (int y = 0; y < AS; y++) begin
            pulse_line();
            pulse_ack();
        end
        pulse_line();
        chk("R5 vblank set", int'(vblank), 1);
        chk("R5 vint_pend set", int'(vint_pend), 1);
        pulse_frame();
        chk("R1 restart clears vblank", int'(vblank), 0);
        chk("R1 restart clears vint_pend", int'(vint_pend), 0);
        repeat (LAG + 2) @(negedge clk);
        chk("R1 lag cancelled", int'(irq_req6), 0);
        pulse_ack();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule